// File: doc/BRIEF.md
# Circular Command Queue Consumer

This block sits between a power-of-two ring of commands held in memory and the unit that carries those commands out. Software places commands in memory, then moves the producer pointer forward through a small register interface. Whenever the queue is enabled, holds no error and is not empty, the block computes the address of the entry at the consumer index and fetches it over a request/response memory port. It classifies the opcode in the low byte and hands each recognised command to an executor port. The consumer pointer moves forward only after the executor reports that the command has finished.

Each pointer has two parts. The low `log2size` bits are the slot index, and the bit just above them is a wrap flag, so a full queue and an empty queue can be told apart. The consumer register also holds a four-bit error code above the pointer. A pointer increment never touches this code. When an opcode is not recognised, or when a fetch returns an error, the block writes a code into this field, stops and raises an interrupt. Software restarts the queue by writing the consumer register with the field cleared.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset every register reads zero, `queue_empty` is 1, and `err_irq`, `mem_req_valid` and `exec_valid` are 0. The register offsets are: 0 control (bit 0 command enable, bit 1 event enable), 1 base, 2 log2size, 3 producer, 4 consumer.
- R2: `queue_empty` is 1 when producer and consumer are equal in index and wrap bits. `queue_full` is 1 when the indices are equal and the wrap bits differ. Both are never 1 at once.
- R3: The fetch address is the base with its low `ENTRY_LOG2` bits cleared, plus the consumer index times 2^`ENTRY_LOG2`.
- R4: No fetch is issued while control bit 0 is clear, even when the queue holds entries.
- R5: Opcodes are classified onto `exec_class` as follows: 0x01–0x02 → 1; 0x03–0x07 → 2; 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A and 0x30 → 3; 0x40 → 4; 0x41 → 5; 0x44–0x45 → 6; 0x46 → 7. Any other value is unknown (class 0) and is never issued to the executor.
- R6: An unknown opcode writes code 1 into consumer bits [27:24] and raises `err_irq`. The consumer pointer does not move and the command is not executed.
- R7: A fetch answered with `mem_rsp_err` writes code 2 into consumer bits [27:24] and raises `err_irq`, without advancing the consumer.
- R8: The consumer pointer advances by one only in the cycle after `exec_done` is seen while `exec_valid` is high. The command is held stable until then. The increment changes only bits [log2size:0], so the wrap bit toggles when the index rolls over.
- R9: The block processes entries one at a time until the queue is empty, with no further producer writes needed. After an error it fetches nothing until software clears the error field, and then it resumes from the consumer pointer.
- R10: A producer or consumer write keeps only bits [log2size:0]. A log2size write above `LOG2_MAX` is clamped to `LOG2_MAX`.
- R11: Control bit 1 drives `evtq_enable` and has no effect on command fetching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_req_valid | output | 1 | Fetch request |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | ADDR_W | Address of the entry being fetched |
| mem_rsp_valid | input | 1 | Fetch response present |
| mem_rsp_data | input | DATA_W | Entry contents, opcode in the low byte |
| mem_rsp_err | input | 1 | Fetch failed |
| exec_valid | output | 1 | Command offered to the executor |
| exec_class | output | 3 | Command class (R5) |
| exec_opcode | output | OPC_W | Raw opcode |
| exec_payload | output | DATA_W | Whole entry |
| exec_done | input | 1 | Executor finished the command |
| queue_empty | output | 1 | Producer equals consumer |
| queue_full | output | 1 | Indices equal, wrap bits differ |
| evtq_enable | output | 1 | Event queue enable (control bit 1) |
| err_irq | output | 1 | Consumer error field is non-zero |

## Verification
The hardest case to reach is a wrap of the consumer index while the error field and the pointer interact: an unknown opcode or an aborted fetch must land exactly on a slot whose wrap bit has already toggled. The stimulus uses a four-slot ring and a table of thirteen commands, known and unknown mixed. Walking the table therefore rolls the pointer over several times, and errors fall on both wrap phases. After each error, software skips or retries the entry by rewriting the consumer register. A held executor keeps `exec_done` low for many cycles, which shows that fetch alone never moves the pointer.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

   typedef enum logic [2:0] {
      CLS_UNKNOWN   = 3'd0,
      CLS_PREFETCH  = 3'd1,
      CLS_CFG_INV   = 3'd2,
      CLS_TLB_INV   = 3'd3,
      CLS_ATC_INV   = 3'd4,
      CLS_PAGE_RESP = 3'd5,
      CLS_STALL     = 3'd6,
      CLS_SYNC      = 3'd7
   } cmd_class_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_EXEC
   } fsm_e;

   localparam int          ERR_W       = 4;
   localparam logic [3:0]  ERR_NONE    = 4'd0;
   localparam logic [3:0]  ERR_ILLEGAL = 4'd1;
   localparam logic [3:0]  ERR_ABORT   = 4'd2;

   localparam logic [2:0]  OFF_CTRL    = 3'd0;
   localparam logic [2:0]  OFF_BASE    = 3'd1;
   localparam logic [2:0]  OFF_LOG2    = 3'd2;
   localparam logic [2:0]  OFF_PROD    = 3'd3;
   localparam logic [2:0]  OFF_CONS    = 3'd4;

endpackage

// File: rtl/cmdq_opcode_decode.sv
module cmdq_opcode_decode
   import cmdq_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opcode,
   output cmd_class_e       cls,
   output logic             known
);

   generate
      if (OPC_W < 7) begin : g_bad_width
         $error("cmdq_opcode_decode: OPC_W must cover opcode 0x46");
      end
   endgenerate

   localparam int OW = OPC_W;

   // Whole value compared; gaps and out-of-table values fall to default.
   always_comb begin
      case (opcode) inside
         OW'(8'h01), OW'(8'h02):                          cls = CLS_PREFETCH;
         [OW'(8'h03):OW'(8'h07)]:                         cls = CLS_CFG_INV;
         [OW'(8'h10):OW'(8'h13)], OW'(8'h18), OW'(8'h1A),
         [OW'(8'h20):OW'(8'h23)], OW'(8'h28), OW'(8'h2A),
         OW'(8'h30):                                      cls = CLS_TLB_INV;
         OW'(8'h40):                                      cls = CLS_ATC_INV;
         OW'(8'h41):                                      cls = CLS_PAGE_RESP;
         OW'(8'h44), OW'(8'h45):                          cls = CLS_STALL;
         OW'(8'h46):                                      cls = CLS_SYNC;
         default:                                         cls = CLS_UNKNOWN;
      endcase
   end

   assign known = (cls != CLS_UNKNOWN);

endmodule

// File: rtl/cmdq_ptr_math.sv
module cmdq_ptr_math #(
   parameter int ADDR_W     = 32,
   parameter int LOG2_MAX   = 8,
   parameter int ENTRY_LOG2 = 4,
   localparam int PTR_W     = LOG2_MAX + 1,
   localparam int L2_W      = $clog2(LOG2_MAX + 1)
) (
   input  logic [L2_W-1:0]   log2size,
   input  logic [ADDR_W-1:0] base,
   input  logic [PTR_W-1:0]  prod,
   input  logic [PTR_W-1:0]  cons,
   output logic [PTR_W-1:0]  wrap_idx_mask,
   output logic [ADDR_W-1:0] entry_addr,
   output logic [PTR_W-1:0]  cons_next,
   output logic              empty,
   output logic              full
);

   logic [PTR_W-1:0] wrap_bit;
   logic [PTR_W-1:0] idx;
   logic [PTR_W-1:0] diff;

   // Per-bit masks derived from the live log2size.
   for (genvar b = 0; b < PTR_W; b++) begin : g_mask
      assign wrap_idx_mask[b] = (L2_W'(b) <= log2size);
      assign wrap_bit[b]      = (L2_W'(b) == log2size);
   end

   assign diff  = (prod ^ cons) & wrap_idx_mask;
   assign empty = (diff == '0);
   assign full  = (diff == wrap_bit);

   assign idx = cons & wrap_idx_mask & ~wrap_bit;

   assign entry_addr = {base[ADDR_W-1:ENTRY_LOG2], {ENTRY_LOG2{1'b0}}}
                     + (ADDR_W'(idx) << ENTRY_LOG2);

   // Bits above the wrap flag are carried through unchanged.
   assign cons_next = ((cons + 1'b1) & wrap_idx_mask) | (cons & ~wrap_idx_mask);

endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer
   import cmdq_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int LOG2_MAX   = 8,
   parameter int ENTRY_LOG2 = 4,
   parameter int OPC_W      = 8,
   parameter int REG_W      = 32,
   parameter int ERR_LSB    = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [2:0]        reg_wr_addr,
   input  logic [REG_W-1:0]  reg_wr_data,
   input  logic [2:0]        reg_rd_addr,
   output logic [REG_W-1:0]  reg_rd_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              exec_valid,
   output logic [2:0]        exec_class,
   output logic [OPC_W-1:0]  exec_opcode,
   output logic [DATA_W-1:0] exec_payload,
   input  logic              exec_done,
   output logic              queue_empty,
   output logic              queue_full,
   output logic              evtq_enable,
   output logic              err_irq
);

   localparam int PTR_W = LOG2_MAX + 1;
   localparam int L2_W  = $clog2(LOG2_MAX + 1);

   generate
      if (ERR_LSB < PTR_W || ERR_LSB + ERR_W > REG_W) begin : g_bad_err_pos
         $error("cmdq_consumer: error field overlaps pointer or register edge");
      end
      if (ADDR_W > REG_W) begin : g_bad_addr
         $error("cmdq_consumer: base must fit one register");
      end
      if (OPC_W > DATA_W || ENTRY_LOG2 >= ADDR_W) begin : g_bad_entry
         $error("cmdq_consumer: entry geometry inconsistent");
      end
   endgenerate

   logic [1:0]        ctrl_q;
   logic [ADDR_W-1:0] base_q;
   logic [L2_W-1:0]   l2_q;
   logic [PTR_W-1:0]  prod_q;
   logic [PTR_W-1:0]  cons_ptr_q;
   logic [ERR_W-1:0]  cons_err_q;
   fsm_e              state_q;
   logic [DATA_W-1:0] cmd_q;
   cmd_class_e        cls_q;

   logic [PTR_W-1:0]  wim;
   logic [PTR_W-1:0]  cons_next;
   logic              empty, full;
   cmd_class_e        dec_cls;
   logic              dec_known;
   logic              cons_wr;

   cmdq_ptr_math #(
      .ADDR_W    (ADDR_W),
      .LOG2_MAX  (LOG2_MAX),
      .ENTRY_LOG2(ENTRY_LOG2)
   ) u_ptr (
      .log2size     (l2_q),
      .base         (base_q),
      .prod         (prod_q),
      .cons         (cons_ptr_q),
      .wrap_idx_mask(wim),
      .entry_addr   (mem_req_addr),
      .cons_next    (cons_next),
      .empty        (empty),
      .full         (full)
   );

   cmdq_opcode_decode #(.OPC_W(OPC_W)) u_dec (
      .opcode(mem_rsp_data[OPC_W-1:0]),
      .cls   (dec_cls),
      .known (dec_known)
   );

   assign cons_wr = reg_wr_en && (reg_wr_addr == OFF_CONS);

   // Register file and consumer state machine.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         base_q     <= '0;
         l2_q       <= '0;
         prod_q     <= '0;
         cons_ptr_q <= '0;
         cons_err_q <= ERR_NONE;
         state_q    <= ST_IDLE;
         cmd_q      <= '0;
         cls_q      <= CLS_UNKNOWN;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (ctrl_q[0] && cons_err_q == ERR_NONE && !empty)
                  state_q <= ST_FETCH;
            end
            ST_FETCH: begin
               if (mem_req_ready) state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (mem_rsp_err) begin
                     cons_err_q <= ERR_ABORT;
                     state_q    <= ST_IDLE;
                  end else if (!dec_known) begin
                     cons_err_q <= ERR_ILLEGAL;
                     state_q    <= ST_IDLE;
                  end else begin
                     cmd_q   <= mem_rsp_data;
                     cls_q   <= dec_cls;
                     state_q <= ST_EXEC;
                  end
               end
            end
            ST_EXEC: begin
               if (exec_done) begin
                  cons_ptr_q <= cons_next;
                  state_q    <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase

         if (reg_wr_en) begin
            case (reg_wr_addr)
               OFF_CTRL: ctrl_q <= reg_wr_data[1:0];
               OFF_BASE: base_q <= reg_wr_data[ADDR_W-1:0];
               OFF_LOG2: begin
                  if (reg_wr_data > REG_W'(LOG2_MAX)) l2_q <= L2_W'(LOG2_MAX);
                  else                                l2_q <= reg_wr_data[L2_W-1:0];
               end
               OFF_PROD: prod_q <= reg_wr_data[PTR_W-1:0] & wim;
               OFF_CONS: begin
                  cons_ptr_q <= reg_wr_data[PTR_W-1:0] & wim;
                  cons_err_q <= reg_wr_data[ERR_LSB +: ERR_W];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_rd_addr)
         OFF_CTRL: reg_rd_data = REG_W'(ctrl_q);
         OFF_BASE: reg_rd_data = REG_W'(base_q);
         OFF_LOG2: reg_rd_data = REG_W'(l2_q);
         OFF_PROD: reg_rd_data = REG_W'(prod_q);
         OFF_CONS: reg_rd_data = (REG_W'(cons_err_q) << ERR_LSB) | REG_W'(cons_ptr_q);
         default:  reg_rd_data = '0;
      endcase
   end

   assign mem_req_valid = (state_q == ST_FETCH);
   assign exec_valid    = (state_q == ST_EXEC);
   assign exec_class    = cls_q;
   assign exec_opcode   = cmd_q[OPC_W-1:0];
   assign exec_payload  = cmd_q;
   assign queue_empty   = empty;
   assign queue_full    = full;
   assign evtq_enable   = ctrl_q[1];
   assign err_irq       = (cons_err_q != ERR_NONE);

   // ---------------- assertions ----------------
   assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(queue_full && queue_empty));

   assert_fetch_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> $past(ctrl_q[0]));

   assert_exec_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exec_valid |-> exec_class != 3'd0);

   assert_err_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(err_irq) && !$past(cons_wr)) |-> (!mem_req_valid && !exec_valid));

   assert_cmd_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && !exec_done) |=> (exec_valid && $stable(exec_payload)));

   assert_adv_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((cons_ptr_q != $past(cons_ptr_q)) && !$past(cons_wr))
         |-> $past(exec_valid && exec_done));

   assert_fetch_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> ($past(cons_err_q) == ERR_NONE));

endmodule

// File: tb/cmdq_consumer_test.sv
module cmdq_consumer_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE_RAW = 32'h0000_1007;
   localparam logic [31:0] BASE_AL  = 32'h0000_1000;

   // {opcode, expected class}; class 0 means unknown
   localparam int NVEC = 13;
   localparam logic [10:0] VEC [0:NVEC-1] = '{
      {8'h01, 3'd1}, {8'h07, 3'd2}, {8'h00, 3'd0}, {8'h13, 3'd3},
      {8'h14, 3'd0}, {8'h1A, 3'd3}, {8'h30, 3'd3}, {8'h40, 3'd4},
      {8'h41, 3'd5}, {8'h42, 3'd0}, {8'h45, 3'd6}, {8'h46, 3'd7},
      {8'hFF, 3'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_wr_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic [2:0]  reg_rd_addr = '0;
   logic [31:0] reg_rd_data;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        mem_rsp_err = 1'b0;
   logic        exec_valid;
   logic [2:0]  exec_class;
   logic [7:0]  exec_opcode;
   logic [63:0] exec_payload;
   logic        exec_done = 1'b0;
   logic        queue_empty, queue_full, evtq_enable, err_irq;

   cmdq_consumer uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .exec_valid(exec_valid), .exec_class(exec_class), .exec_opcode(exec_opcode),
      .exec_payload(exec_payload), .exec_done(exec_done),
      .queue_empty(queue_empty), .queue_full(queue_full),
      .evtq_enable(evtq_enable), .err_irq(err_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int          n_tests = 0;
   int          n_fail  = 0;
   int          cyc     = 0;
   logic [63:0] mem [0:3];
   logic        inject_err = 1'b0;
   logic        hold_exec  = 1'b0;
   logic        rsp_pending = 1'b0;
   int          fetch_cnt = 0;
   int          exec_cnt  = 0;
   logic [31:0] last_addr = '0;
   logic [2:0]  last_cls  = '0;
   logic [7:0]  last_opc  = '0;
   logic [2:0]  exp_prod  = '0;
   logic [2:0]  exp_cons  = '0;

   // Memory model: one-cycle response, driven away from the active edge.
   always @(negedge clk) begin
      if (rsp_pending) begin
         mem_rsp_valid = 1'b1;
         rsp_pending   = 1'b0;
      end else begin
         mem_rsp_valid = 1'b0;
      end
      if (mem_req_valid && mem_req_ready) begin
         rsp_pending  = 1'b1;
         last_addr    = mem_req_addr;
         mem_rsp_data = mem[mem_req_addr[5:4]];
         mem_rsp_err  = inject_err;
         fetch_cnt++;
      end
   end

   // Executor model: completes one cycle after a command appears.
   always @(negedge clk) begin
      if (exec_valid && !exec_done && !hold_exec) begin
         exec_done = 1'b1;
         last_cls  = exec_class;
         last_opc  = exec_opcode;
         exec_cnt++;
      end else begin
         exec_done = 1'b0;
      end
   end

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd_addr = a;
      #1;
      d = reg_rd_data;
   endtask

   task automatic push(input logic [7:0] opc);
      mem[exp_prod[1:0]] = {48'hA5A5_0000_0000, 8'h00, opc};
      exp_prod = exp_prod + 3'd1;
      reg_wr(3'd3, {29'd0, exp_prod});
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
      for (int t = 0; t < 200; t++) begin
         if (err_irq || (queue_empty && !exec_valid && !mem_req_valid)) break;
         @(negedge clk);
      end
   endtask

   logic [31:0] rd;

   initial begin
      for (int i = 0; i < 4; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 5; a++) begin
         reg_rd(3'(a), rd);
         check(rd == 32'd0, "R1 reg reset", rd, 0);
      end
      check(queue_empty && !err_irq && !mem_req_valid && !exec_valid, "R1 outputs",
            {queue_empty, err_irq, mem_req_valid, exec_valid}, 4'b1000);

      // R10: log2size clamp and pointer masking
      reg_wr(3'd2, 32'd15);
      reg_rd(3'd2, rd);
      check(rd == 32'd8, "R10 log2 clamp", rd, 8);
      reg_wr(3'd2, 32'd2);
      reg_wr(3'd1, BASE_RAW);
      reg_wr(3'd3, 32'hFF);
      reg_rd(3'd3, rd);
      check(rd == 32'd7, "R10 prod mask", rd, 7);

      // R4: disabled, entries pending, no fetch
      repeat (20) @(negedge clk);
      check(fetch_cnt == 0, "R4 no fetch when disabled", fetch_cnt, 0);

      // R2: full and empty with wrap bit
      reg_wr(3'd3, 32'd4);
      check(queue_full && !queue_empty, "R2 full", {queue_full, queue_empty}, 2'b10);
      reg_wr(3'd3, 32'd3);
      check(!queue_full && !queue_empty, "R2 partial", {queue_full, queue_empty}, 2'b00);
      reg_wr(3'd3, 32'd0);
      check(queue_empty && !queue_full, "R2 empty", {queue_full, queue_empty}, 2'b01);

      // R11: event enable only, still no fetch
      mem[0] = 64'h01;
      reg_wr(3'd3, 32'd1);
      reg_wr(3'd0, 32'd2);
      repeat (10) @(negedge clk);
      check(evtq_enable && fetch_cnt == 0, "R11 event bit isolated", fetch_cnt, 0);
      reg_wr(3'd3, 32'd0);
      reg_wr(3'd0, 32'd3);

      // Table walk: R3, R5, R6, R8, R9 across several wraps
      for (int v = 0; v < NVEC; v++) begin
         logic [7:0]  opc;
         logic [2:0]  ecls;
         logic [2:0]  idx;
         int          start;
         opc   = VEC[v][10:3];
         ecls  = VEC[v][2:0];
         idx   = exp_cons & 3'd3;
         start = exec_cnt;
         push(opc);
         settle();
         check(last_addr == BASE_AL + 32'(idx) * 32'd16, "R3 entry address",
               last_addr, BASE_AL + 32'(idx) * 32'd16);
         reg_rd(3'd4, rd);
         if (ecls == 3'd0) begin
            check(rd[27:24] == 4'd1 && rd[3:0] == {1'b0, exp_cons} && err_irq
                  && exec_cnt == start, "R6 illegal opcode", rd, {4'd1, 24'd0} | exp_cons);
            exp_cons = exp_cons + 3'd1;
            reg_wr(3'd4, {29'd0, exp_cons});
            repeat (2) @(negedge clk);
            check(!err_irq && queue_empty, "R9 clear resumes", err_irq, 0);
         end else begin
            check(exec_cnt == start + 1 && last_cls == ecls && last_opc == opc,
                  "R5 class", {last_opc, 5'd0, last_cls}, {opc, 5'd0, ecls});
            exp_cons = exp_cons + 3'd1;
            check(rd == {29'd0, exp_cons}, "R8 cons advance/wrap", rd, exp_cons);
         end
      end

      // R8: no advance while executor holds
      hold_exec = 1'b1;
      push(8'h46);
      repeat (15) @(negedge clk);
      reg_rd(3'd4, rd);
      check(exec_valid && rd == {29'd0, exp_cons}, "R8 hold no advance", rd, exp_cons);
      hold_exec = 1'b0;
      settle();
      exp_cons = exp_cons + 3'd1;
      reg_rd(3'd4, rd);
      check(rd == {29'd0, exp_cons}, "R8 advance after done", rd, exp_cons);

      // R7: fetch abort, then retry of the same entry
      inject_err = 1'b1;
      push(8'h02);
      settle();
      reg_rd(3'd4, rd);
      check(rd == ({4'd2, 24'd0} | {29'd0, exp_cons}) && err_irq, "R7 abort code",
            rd, {4'd2, 24'd0} | exp_cons);
      begin
         int f0;
         f0 = fetch_cnt;
         repeat (10) @(negedge clk);
         check(fetch_cnt == f0, "R9 halted on error", fetch_cnt, f0);
      end
      inject_err = 1'b0;
      reg_wr(3'd4, {29'd0, exp_cons});
      settle();
      exp_cons = exp_cons + 3'd1;
      reg_rd(3'd4, rd);
      check(rd == {29'd0, exp_cons} && last_opc == 8'h02, "R9 retry after clear",
            rd, exp_cons);

      // R9: several entries from one producer write
      begin
         int e0;
         e0 = exec_cnt;
         mem[exp_prod[1:0]]          = 64'h03;
         mem[(exp_prod + 3'd1) & 3'd3] = 64'h10;
         mem[(exp_prod + 3'd2) & 3'd3] = 64'h46;
         exp_prod = exp_prod + 3'd3;
         reg_wr(3'd3, {29'd0, exp_prod});
         settle();
         exp_cons = exp_cons + 3'd3;
         reg_rd(3'd4, rd);
         check(exec_cnt == e0 + 3 && rd == {29'd0, exp_cons}, "R9 drains queue",
               exec_cnt - e0, 3);
      end

      finish_run();
   end

endmodule